// File: doc/BRIEF.md
# Multi-queue notification ring writer

This block accepts 16-byte notification records, each tagged with a queue number, and stores every record in a circular buffer in memory. Each queue has its own buffer. In the default build there are ten queues. Software sets up each buffer through a 32-bit register port with a 64-bit base address, a size in bytes and a head pointer. The head pointer marks how far the consumer has read. Software can read back the tail pointer, which is the byte offset of the next free slot and is kept by the hardware.

An enable register switches queues on and off, one bit per queue. A software backpressure mask stalls record intake for selected queues. Accepted records leave on a write-request port that carries a 64-bit address and 128 bits of data. Bit 31 of each record is replaced with a phase flag. The flag flips every time a queue's buffer wraps, so a consumer polling memory can tell fresh entries from stale ones.

A build parameter reduces the block to one queue. In that build the queue tag on incoming records is ignored, and only the first register window exists.

Top module: `nq_ring_writer`

## Requirements
- R1: A record accepted for queue q is written at base(q) + tail(q). The tail starts at 0, stays a multiple of 16, and advances by 16 per record. When the advanced value would be greater than or equal to the programmed size, the tail returns to 0.
- R2: The written data equals the record except bit 31, which is byte 3 bit 7. Bit 31 carries the queue's phase flag. The flag is 1 after reset and inverts each time the tail wraps to 0.
- R3: When the advanced tail would equal the head register, the queue is full. Records for that queue are stalled (rec_ready low), and nothing is written until software moves the head.
- R4: Queue n's register window starts at 0x100 + 0x28·n. Within it, base low is at +0x00, base high at +0x04, size at +0x08, head at +0x0C and tail (read-only) at +0x10. A read returns its data on reg_rdata one cycle after reg_re.
- R5: A write or read that falls in the window of a queue index at or above the queue count is ignored. It changes no register, a read of it returns 0, and reg_err is high in the cycle after the access.
- R6: With SINGLE_Q set, only queue 0 exists. Its window starts at 0x100, and the window that would belong to index 1 (0x128 onward) is flagged as in R5. Every record goes to queue 0 whatever its tag.
- R7: Register 0x14 holds one enable bit per queue (bit n for queue n), and all bits are 0 after reset. A disabled queue stalls its records. Once a queue is disabled and has no write outstanding, its tail reads 0 and its phase returns to 1.
- R8: Register 0x08 is the backpressure mask, with bit n for queue n. A set bit stalls that queue's records. 0x3FF stalls all ten queues, and 0 stalls none.
- R9: Writes to a queue's base or size registers while that queue is enabled are ignored. Head writes are always taken.
- R10: While mem_req is high and mem_ready is low, mem_req, mem_addr and mem_data hold. A new record is accepted only when the output slot is empty or is being emptied in the same cycle.
- R11: In the ten-queue build, a record tagged 10 or higher is consumed (rec_ready high) and dropped without a memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_re |
| reg_err | output | 1 | Access hit a non-existent queue window |
| rec_valid | input | 1 | Record offered |
| rec_qid | input | QID_W (4) | Queue tag of the offered record |
| rec_data | input | 128 | Record payload |
| rec_ready | output | 1 | Record taken this cycle |
| mem_req | output | 1 | Memory write request pending |
| mem_addr | output | 64 | Write byte address |
| mem_data | output | 128 | Write data with phase flag in bit 31 |
| mem_ready | input | 1 | Memory accepts the pending write |

## Verification
Two functions can collide in one cycle. The first is a record acceptance that advances the tail to the value of the head. The second is a software head write that lands while records for the same queue are streaming. The bench provokes this by moving the head on a queue only when its model predicts the next record would fill it, and it does so under random memory backpressure. This means head writes, stalled outputs and tail advances interleave. Every memory write is compared against the model's address and phase, and a full queue must stall rather than overwrite. The wrap of a three-slot queue is also checked directly. Software has to release the head twice, and the first record after the wrap must carry an inverted phase flag.

// File: rtl/nqw_pkg.sv
// Shared constants and types for the notification ring writer.
// Assumes byte addressing on the register port and 16-byte records.
package nqw_pkg;
    localparam int REG_AW    = 12;
    localparam int REC_BYTES = 16;
    localparam int REC_W     = REC_BYTES * 8;
    localparam int MADDR_W   = 64;
    localparam int PHASE_POS = 31;

    localparam logic [REG_AW-1:0] OFF_BP     = 12'h008;
    localparam logic [REG_AW-1:0] OFF_EN     = 12'h014;
    localparam logic [REG_AW-1:0] OFF_WIN    = 12'h100;
    localparam logic [REG_AW-1:0] WIN_STRIDE = 12'h028;

    typedef enum logic [2:0] {
        F_BASE_LO, F_BASE_HI, F_SIZE, F_HEAD, F_TAIL, F_NONE
    } fld_e;
endpackage

// File: rtl/nqw_regs.sv
// Register file: global enable and backpressure masks plus one window per
// queue. Assumes one access per cycle; reads are registered.
module nqw_regs
    import nqw_pkg::*;
#(
    parameter int NQ = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_we,
    input  logic                      reg_re,
    input  logic [REG_AW-1:0]         reg_addr,
    input  logic [31:0]               reg_wdata,
    input  logic [NQ-1:0][31:0]       tail_i,
    output logic [31:0]               reg_rdata,
    output logic                      reg_err,
    output logic [NQ-1:0][MADDR_W-1:0] base_o,
    output logic [NQ-1:0][31:0]       size_o,
    output logic [NQ-1:0][31:0]       head_o,
    output logic [NQ-1:0]             en_o,
    output logic [NQ-1:0]             bp_o
);
    localparam logic [REG_AW-1:0] NQ_L = REG_AW'(NQ);

    logic [REG_AW-1:0] off, widx, fofs;
    logic              in_win, idx_ok;
    fld_e              fld;
    logic [31:0]       rd_mux;

    // Split the address into queue index and field offset.
    always_comb begin
        in_win = reg_addr >= OFF_WIN;
        off    = reg_addr - OFF_WIN;
        widx   = off / WIN_STRIDE;
        fofs   = off - widx * WIN_STRIDE;
        idx_ok = in_win && (widx < NQ_L);
        case (fofs)
            12'h000: fld = F_BASE_LO;
            12'h004: fld = F_BASE_HI;
            12'h008: fld = F_SIZE;
            12'h00C: fld = F_HEAD;
            12'h010: fld = F_TAIL;
            default: fld = F_NONE;
        endcase
    end

    // Register updates; base and size are locked while the queue runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o <= '0;
            size_o <= '0;
            head_o <= '0;
            en_o   <= '0;
            bp_o   <= '0;
        end else if (reg_we) begin
            if (reg_addr == OFF_BP) bp_o <= reg_wdata[NQ-1:0];
            if (reg_addr == OFF_EN) en_o <= reg_wdata[NQ-1:0];
            for (int i = 0; i < NQ; i++) begin
                if (idx_ok && widx == REG_AW'(i)) begin
                    case (fld)
                        F_BASE_LO: if (!en_o[i]) base_o[i][31:0]  <= reg_wdata;
                        F_BASE_HI: if (!en_o[i]) base_o[i][63:32] <= reg_wdata;
                        F_SIZE:    if (!en_o[i]) size_o[i]        <= reg_wdata;
                        F_HEAD:    head_o[i] <= reg_wdata;
                        default:   ;
                    endcase
                end
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        rd_mux = '0;
        if (reg_addr == OFF_BP) rd_mux[NQ-1:0] = bp_o;
        if (reg_addr == OFF_EN) rd_mux[NQ-1:0] = en_o;
        for (int i = 0; i < NQ; i++) begin
            if (idx_ok && widx == REG_AW'(i)) begin
                case (fld)
                    F_BASE_LO: rd_mux = base_o[i][31:0];
                    F_BASE_HI: rd_mux = base_o[i][63:32];
                    F_SIZE:    rd_mux = size_o[i];
                    F_HEAD:    rd_mux = head_o[i];
                    F_TAIL:    rd_mux = tail_i[i];
                    default:   ;
                endcase
            end
        end
    end

    // Registered read data and out-of-range flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
            reg_err   <= 1'b0;
        end else begin
            if (reg_re) reg_rdata <= rd_mux;
            reg_err <= (reg_we || reg_re) && in_win && !idx_ok;
        end
    end

    AST_BAD_IDX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && in_win && !idx_ok |=> $stable(base_o) && $stable(size_o) && $stable(head_o)); // R5

    generate
        for (genvar g = 0; g < NQ; g++) begin : g_lock
            AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
                en_o[g] |=> $stable(base_o[g]) && $stable(size_o[g])); // R9
        end
    endgenerate
endmodule

// File: rtl/nqw_tail.sv
// Per-queue tail pointer and phase flag. Advances by one record on adv_i,
// wraps at the programmed size, and clears once disabled and idle.
// Assumes the caller never advances a full queue.
module nqw_tail
    import nqw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_i,
    input  logic        busy_i,
    input  logic        adv_i,
    input  logic [31:0] size_i,
    input  logic [31:0] head_i,
    output logic [31:0] tail_o,
    output logic        phase_o,
    output logic        full_o
);
    logic [32:0] step;
    logic [31:0] nxt;

    // Next slot offset with wrap at the buffer size.
    always_comb begin
        step   = {1'b0, tail_o} + 33'(REC_BYTES);
        nxt    = (step >= {1'b0, size_i}) ? 32'd0 : step[31:0];
        full_o = (nxt == head_i);
    end

    // Tail and phase state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_o  <= '0;
            phase_o <= 1'b1;
        end else if (adv_i) begin
            tail_o <= nxt;
            if (nxt == 32'd0) phase_o <= ~phase_o;
        end else if (!en_i && !busy_i) begin
            tail_o  <= '0;
            phase_o <= 1'b1;
        end
    end

    AST_TAIL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        tail_o[3:0] == 4'd0); // R1
    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |-> !full_o); // R3
    AST_WRAP_FLIPS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i && nxt == 32'd0 |=> phase_o != $past(phase_o)); // R2
    AST_DRAINED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i && !busy_i && !adv_i |=> tail_o == 32'd0); // R7
endmodule

// File: rtl/nq_ring_writer.sv
// Top level: routes tagged records to per-queue rings, stamps the phase
// flag and presents one write at a time on the memory port.
// Assumes mem_ready may stall indefinitely; one record held in flight.
module nq_ring_writer
    import nqw_pkg::*;
#(
    parameter int NUM_Q    = 10,
    parameter bit SINGLE_Q = 1'b0,
    localparam int QID_W   = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic               reg_re,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               reg_err,
    input  logic               rec_valid,
    input  logic [QID_W-1:0]   rec_qid,
    input  logic [REC_W-1:0]   rec_data,
    output logic               rec_ready,
    output logic               mem_req,
    output logic [MADDR_W-1:0] mem_addr,
    output logic [REC_W-1:0]   mem_data,
    input  logic               mem_ready
);
    localparam int NQ = SINGLE_Q ? 1 : NUM_Q;

    logic [NQ-1:0][MADDR_W-1:0] base;
    logic [NQ-1:0][31:0]        size, head, tail;
    logic [NQ-1:0]              en, bp, phase, full, busy, adv;
    logic [QID_W-1:0]           sel, out_q;
    logic                       qid_ok, slot_free, q_go, accept;
    logic [MADDR_W-1:0]         pk_base;
    logic [31:0]                pk_tail;
    logic                       pk_phase, pk_en, pk_bp, pk_full;
    logic [REC_W-1:0]           wr_data;

    nqw_regs #(.NQ(NQ)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .tail_i(tail),
        .reg_rdata(reg_rdata), .reg_err(reg_err), .base_o(base),
        .size_o(size), .head_o(head), .en_o(en), .bp_o(bp)
    );

    generate
        for (genvar g = 0; g < NQ; g++) begin : g_q
            nqw_tail u_tail (
                .clk(clk), .rst_n(rst_n), .en_i(en[g]), .busy_i(busy[g]),
                .adv_i(adv[g]), .size_i(size[g]), .head_i(head[g]),
                .tail_o(tail[g]), .phase_o(phase[g]), .full_o(full[g])
            );
        end
    endgenerate

    // Pick the addressed queue's state and decide acceptance.
    always_comb begin
        sel      = SINGLE_Q ? '0 : rec_qid;
        qid_ok   = SINGLE_Q ? 1'b1 : ({1'b0, rec_qid} < (QID_W+1)'(NUM_Q));
        pk_base  = '0;
        pk_tail  = '0;
        pk_phase = 1'b0;
        pk_en    = 1'b0;
        pk_bp    = 1'b0;
        pk_full  = 1'b0;
        for (int i = 0; i < NQ; i++) begin
            busy[i] = mem_req && (out_q == QID_W'(i));
            if (sel == QID_W'(i)) begin
                pk_base  = base[i];
                pk_tail  = tail[i];
                pk_phase = phase[i];
                pk_en    = en[i];
                pk_bp    = bp[i];
                pk_full  = full[i];
            end
        end
        slot_free = !mem_req || mem_ready;
        q_go      = pk_en && !pk_bp && !pk_full;
        rec_ready = !qid_ok || (slot_free && q_go);
        accept    = rec_valid && qid_ok && slot_free && q_go;
        for (int i = 0; i < NQ; i++) adv[i] = accept && (sel == QID_W'(i));
        wr_data            = rec_data;
        wr_data[PHASE_POS] = pk_phase;
    end

    // Output slot holding one write request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req  <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
            out_q    <= '0;
        end else if (accept) begin
            mem_req  <= 1'b1;
            mem_addr <= pk_base + {32'd0, pk_tail};
            mem_data <= wr_data;
            out_q    <= sel;
        end else if (mem_ready) begin
            mem_req <= 1'b0;
        end
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_data)); // R10
    AST_DISABLED_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && qid_ok && !pk_en |-> !rec_ready); // R7
    AST_BP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && qid_ok && pk_bp |-> !rec_ready); // R8
    AST_BAD_QID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && !qid_ok && slot_free |=> !mem_req); // R11
endmodule

// File: tb/tb_nq_ring_writer.sv
module tb_nq_ring_writer;
    import nqw_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int NQ = 10;

    logic clk = 0, rst_n = 0;
    logic reg_we = 0, reg_re = 0, sq_we = 0, sq_re = 0;
    logic [11:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata, sq_rdata;
    logic reg_err, sq_err;
    logic rec_valid = 0, rec_ready, sq_valid = 0, sq_ready;
    logic [3:0] rec_qid = 0, sq_qid = 0;
    logic [127:0] rec_data = 0, sq_data = 0, mem_data, sq_mdata;
    logic mem_req, mem_ready = 1, sq_mreq;
    logic [63:0] mem_addr, sq_maddr;

    always #(CLK_PERIOD/2) clk = ~clk;

    nq_ring_writer dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_err(reg_err), .rec_valid(rec_valid), .rec_qid(rec_qid),
        .rec_data(rec_data), .rec_ready(rec_ready), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready));

    nq_ring_writer #(.SINGLE_Q(1'b1)) dut_sq (
        .clk(clk), .rst_n(rst_n), .reg_we(sq_we), .reg_re(sq_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(sq_rdata),
        .reg_err(sq_err), .rec_valid(sq_valid), .rec_qid(sq_qid),
        .rec_data(sq_data), .rec_ready(sq_ready), .mem_req(sq_mreq),
        .mem_addr(sq_maddr), .mem_data(sq_mdata), .mem_ready(1'b1));

    int total = 0, bad = 0, mr_mode = 0;
    bit done = 0;
    logic [63:0]  ea[$];
    logic [127:0] ed[$];
    logic [127:0] last_d;
    logic [63:0]  m_base[NQ];
    logic [31:0]  m_size[NQ], m_head[NQ], m_tail[NQ];
    bit           m_ph[NQ];
    logic [NQ-1:0] m_en = 0;

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] win(int q, logic [11:0] f);
        return 12'h100 + 12'(q * 40) + f;
    endfunction

    function automatic logic [31:0] next_t(int q);
        logic [32:0] s = {1'b0, m_tail[q]} + 33'd16;
        return (s >= {1'b0, m_size[q]}) ? 32'd0 : s[31:0];
    endfunction

    // Memory-side ready pattern.
    always @(negedge clk)
        mem_ready <= (mr_mode == 0) ? 1'b1 : (mr_mode == 1) ? 1'($urandom % 2) : 1'b0;

    // Memory write monitor against the model queue.
    always @(negedge clk) begin : mon
        logic [63:0] a;
        logic [127:0] d;
        #1;
        if (rst_n && mem_req && mem_ready) begin
            last_d = mem_data;
            if (ea.size() == 0) chk(0, "R11 unexpected write", mem_addr, 0);
            else begin
                a = ea.pop_front();
                d = ed.pop_front();
                chk(mem_addr == a, "R1 write address", mem_addr, a);
                chk(mem_data == d, "R2 write data/phase", mem_data[63:0], d[63:0]);
            end
        end
    end

    task automatic wr(bit sq, logic [11:0] a, logic [31:0] d, output bit err);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = !sq; sq_we = sq;
        @(negedge clk);
        reg_we = 0; sq_we = 0;
        err = sq ? sq_err : reg_err;
    endtask

    task automatic rd(bit sq, logic [11:0] a, output logic [31:0] v, output bit err);
        @(negedge clk);
        reg_addr = a; reg_re = !sq; sq_re = sq;
        @(negedge clk);
        reg_re = 0; sq_re = 0;
        v = sq ? sq_rdata : reg_rdata;
        err = sq ? sq_err : reg_err;
    endtask

    task automatic cfg(int q, logic [63:0] b, logic [31:0] s, logic [31:0] h);
        bit e;
        wr(0, win(q, 12'h0), b[31:0], e);
        wr(0, win(q, 12'h4), b[63:32], e);
        wr(0, win(q, 12'h8), s, e);
        wr(0, win(q, 12'hC), h, e);
        m_base[q] = b; m_size[q] = s; m_head[q] = h;
    endtask

    task automatic set_en(logic [NQ-1:0] m);
        bit e;
        wr(0, 12'h014, 32'(m), e);
        for (int q = 0; q < NQ; q++)
            if (!m[q]) begin m_tail[q] = 0; m_ph[q] = 1; end
        m_en = m;
    endtask

    task automatic set_head(int q, logic [31:0] h);
        bit e;
        wr(0, win(q, 12'hC), h, e);
        m_head[q] = h;
    endtask

    task automatic send(logic [3:0] q, logic [127:0] d, int maxcyc, output bit ok);
        logic [127:0] x;
        ok = 0;
        @(negedge clk);
        rec_valid = 1; rec_qid = q; rec_data = d;
        for (int c = 0; c < maxcyc && !ok; c++) begin
            #1;
            if (rec_ready) begin
                ok = 1;
                if (q < NQ) begin
                    x = d; x[31] = m_ph[q];
                    ea.push_back(m_base[q] + {32'd0, m_tail[q]});
                    ed.push_back(x);
                    if (next_t(q) == 0) m_ph[q] = ~m_ph[q];
                    m_tail[q] = next_t(q);
                end
            end
            @(negedge clk);
        end
        rec_valid = 0;
    endtask

    task automatic drain();
        while (ea.size() != 0 || mem_req) @(negedge clk);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R1 actual=hang expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        bit e, ok;
        logic [63:0] b;
        void'($urandom(32'h5eed_0042));
        for (int q = 0; q < NQ; q++) begin m_tail[q] = 0; m_ph[q] = 1; m_head[q] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;

        // Reset state
        rd(0, 12'h014, v, e);  chk(v == 0, "R7 enable reset", v, 0);
        rd(0, win(5, 12'h10), v, e); chk(v == 0, "R1 tail reset", v, 0);
        chk(mem_req == 0, "R10 no request after reset", mem_req, 0);
        @(negedge clk); rec_valid = 1; rec_qid = 0; #1;
        chk(rec_ready == 0, "R7 disabled queue stalls", rec_ready, 0);
        rec_valid = 0;

        // Window layout
        cfg(3, 64'h0000_00AB_0000_1200, 64, 0);
        rd(0, win(3, 12'h4), v, e); chk(v == 32'hAB, "R4 base_hi q3", v, 32'hAB);
        rd(0, win(3, 12'h0), v, e); chk(v == 32'h1200, "R4 base_lo q3", v, 32'h1200);
        rd(0, win(3, 12'h8), v, e); chk(v == 64, "R4 size q3", v, 64);

        // Random configuration and traffic
        for (int q = 0; q < NQ; q++) begin
            b = {$urandom, $urandom};
            cfg(q, b & ~64'hF, 32'(16 * (2 + $urandom % 5)), 0);
        end
        rd(0, win(9, 12'hC), v, e); chk(v == 0 && !e, "R4 head q9", v, 0);

        // Out-of-range window
        wr(0, 12'h290, 32'hDEAD_BEEF, e); chk(e == 1, "R5 flag on write", e, 1);
        rd(0, 12'h290, v, e); chk(v == 0 && e, "R5 read returns 0", v, 0);
        rd(0, win(9, 12'h0), v, e);
        chk(v == m_base[9][31:0], "R5 neighbour untouched", v, m_base[9][31:0]);

        set_en(10'h3FF);
        mr_mode = 1;
        for (int i = 0; i < 300; i++) begin
            int q = int'($urandom % NQ);
            if (next_t(q) == m_head[q]) set_head(q, m_tail[q]);
            send(4'(q), {$urandom, $urandom, $urandom, $urandom}, 60, ok);
            chk(ok, "R1 random record accepted", ok, 1);
        end
        mr_mode = 0;
        drain();

        // Config lock while enabled
        wr(0, win(4, 12'h0), 32'h5550, e);
        rd(0, win(4, 12'h0), v, e);
        chk(v == m_base[4][31:0], "R9 base locked", v, m_base[4][31:0]);
        wr(0, win(4, 12'h8), 32'h400, e);
        rd(0, win(4, 12'h8), v, e);
        chk(v == m_size[4], "R9 size locked", v, m_size[4]);

        // Backpressure mask
        if (next_t(5) == m_head[5]) set_head(5, m_tail[5]);
        wr(0, 12'h008, 32'h020, e);
        send(4'd5, 128'h1234, 6, ok); chk(!ok, "R8 mask stalls", ok, 0);
        wr(0, 12'h008, 32'h3FF, e);
        send(4'd1, 128'h99, 4, ok); chk(!ok, "R8 full mask stalls", ok, 0);
        wr(0, 12'h008, 32'h0, e);
        send(4'd5, 128'h1234, 6, ok); chk(ok, "R8 mask cleared", ok, 1);
        drain();

        // Memory stall holds request
        if (next_t(6) == m_head[6]) set_head(6, m_tail[6]);
        mr_mode = 2;
        send(4'd6, 128'hABCD, 4, ok);
        repeat (3) @(negedge clk);
        #1;
        chk(mem_req == 1, "R10 request held", mem_req, 1);
        chk(mem_addr == ea[0], "R10 address held", mem_addr, ea[0]);
        send(4'd7, 128'h1, 3, ok); chk(!ok, "R10 no accept while slot busy", ok, 0);
        mr_mode = 0;
        drain();

        // Out-of-range tag dropped
        send(4'd12, 128'h77, 3, ok); chk(ok, "R11 bad tag consumed", ok, 1);
        repeat (3) @(negedge clk);
        chk(mem_req == 0, "R11 no write", mem_req, 0);

        // Full queue and wrap
        set_en(m_en & ~10'h004);
        drain();
        cfg(2, 64'h0000_0001_0000_8000, 48, 0);
        set_en(m_en | 10'h004);
        send(4'd2, 128'hA0, 6, ok); chk(ok, "R3 slot 1", ok, 1);
        send(4'd2, 128'hA1, 6, ok); chk(ok, "R3 slot 2", ok, 1);
        send(4'd2, 128'hA2, 8, ok); chk(!ok, "R3 full stalls", ok, 0);
        drain();
        set_head(2, 16);
        send(4'd2, 128'hA2, 6, ok); chk(ok, "R3 head moved", ok, 1);
        set_head(2, 32);
        send(4'd2, 128'hFFFF_FFFF, 6, ok); chk(ok, "R1 wrapped slot", ok, 1);
        drain();
        chk(last_d[31] == 0, "R2 phase inverted after wrap", last_d[31], 0);

        // Disable clears tails
        set_en(0);
        drain();
        repeat (2) @(negedge clk);
        rd(0, win(2, 12'h10), v, e); chk(v == 0, "R7 tail zero q2", v, 0);
        rd(0, win(7, 12'h10), v, e); chk(v == 0, "R7 tail zero q7", v, 0);
        @(negedge clk); rec_valid = 1; rec_qid = 1; #1;
        chk(rec_ready == 0, "R7 stall after disable", rec_ready, 0);
        rec_valid = 0;

        // Single-queue build
        wr(1, 12'h100, 32'h4000, e);
        wr(1, 12'h104, 32'h0, e);
        wr(1, 12'h108, 32'd64, e);
        wr(1, 12'h014, 32'h1, e);
        rd(1, 12'h100, v, e); chk(v == 32'h4000 && !e, "R6 base at window 0", v, 32'h4000);
        rd(1, 12'h128, v, e); chk(e == 1 && v == 0, "R6 index 1 flagged", e, 1);
        @(negedge clk); sq_valid = 1; sq_qid = 7; sq_data = 128'h5; #1;
        chk(sq_ready == 1, "R6 tag ignored", sq_ready, 1);
        @(negedge clk); sq_valid = 0; #1;
        chk(sq_mreq && sq_maddr == 64'h4000, "R6 write to queue 0", sq_maddr, 64'h4000);
        chk(sq_mdata == 128'h8000_0005, "R2 phase set initially", sq_mdata[63:0], 64'h8000_0005);

        done = 1;
        summary();
        $finish;
    end
endmodule